// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns the single indexed-addressing postbyte of a 16-bit-address, 8-bit-data processor into an effective address. The instruction decoder hands it the postbyte together with the index registers X and Y, the stack pointer, the program counter and the accumulators A and B. The 16-bit accumulator D is A in its upper byte and B in its lower byte. The block then works through a short sequence. It fetches any offset bytes the postbyte calls for from the instruction byte stream, through a request/acknowledge handshake. For the two indirect forms it reads a 16-bit pointer word through a second request/acknowledge port. It finishes with a one-cycle `done` strobe.

At the strobe the block presents several results. `eff_addr` carries the final address and `extra_cycles` the surcharge of the mode. For auto increment and decrement it also gives a write-back of the selected base register. The caller owns the register file and memory. It applies the write-back and charges the cycles. A new request is taken only while the block is idle.

Top module: `idx_addr_gen`

## Requirements
- R1: Postbyte bit 5 = 0 selects a short constant offset. The base register is chosen by bits 7:6, and bits 4:0 form a two's-complement offset from -16 to +15. No bytes are fetched, and `extra_cycles` = 0.
- R2: Bit 5 = 1 with bits 7:6 other than 11 selects auto modify on the base chosen by bits 7:6. The adjust field is bits 3:0: codes 0..7 mean +1..+8 and codes 8..15 mean -8..-1. At `done`, `wb_en` = 1, `wb_sel` holds the base index and `wb_data` = base + adjust. `extra_cycles` = 0. No other mode raises `wb_en`.
- R3: In auto modify, bit 4 = 0 (post) gives `eff_addr` = the unmodified base, and bit 4 = 1 (pre) gives `eff_addr` = the modified base.
- R4: With bits 7:6 = 11 and bit 5 = 1, the base is chosen by bits 4:3. If bits 2:0 = 00x, one byte is fetched and used as a 9-bit signed offset, with postbyte bit 0 as its sign bit. `extra_cycles` = 0.
- R5: With bits 7:6 = 11, bit 5 = 1 and bits 2:0 = 010, two bytes are fetched as a 16-bit offset, the first fetched byte being the high byte. `extra_cycles` = 1.
- R6: With bits 7:6 = 11, bit 5 = 1 and bits 2:0 = 011, a 16-bit offset is fetched (high byte first) and added to the base. One word is read from `mem_addr` = that sum, and `eff_addr` = the word read. `extra_cycles` = 1.
- R7: With bits 7:6 = 11, bit 5 = 1 and bits 2:0 = 1xy, an accumulator offset is added to the base. xy = 00 adds A and xy = 01 adds B, each zero-extended. xy = 10 adds D = {A,B}. `extra_cycles` = 0.
- R8: Code xy = 11 in that group adds D, reads a word at the sum and returns it as `eff_addr`. `extra_cycles` = 1.
- R9: The base index is 0 = X, 1 = Y, 2 = SP, 3 = PC. When the PC is the base, its value is `reg_pc` plus the number of offset bytes fetched for this postbyte.
- R10: Every addition wraps modulo 2^16.
- R11: `done` is high for exactly one cycle per accepted request. `start` is ignored while a request is in progress. The fetch and memory requests are never high together.
- R12: While and right after reset, `done`, `fetch_req` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; taken only when idle |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | PC just after the postbyte |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| fetch_req | output | 1 | Wants the next instruction-stream byte |
| fetch_ack | input | 1 | Byte on `fetch_data` is delivered this cycle |
| fetch_data | input | 8 | Instruction-stream byte |
| mem_req | output | 1 | Word read request for indirect modes |
| mem_addr | output | 16 | Address of the pointer word |
| mem_ack | input | 1 | `mem_rdata` is valid this cycle |
| mem_rdata | input | 16 | Pointer word read |
| done | output | 1 | One-cycle strobe: results valid |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | Base register write-back valid |
| wb_sel | output | 2 | Index of the base register to write |
| wb_data | output | 16 | Write-back value |
| extra_cycles | output | 2 | Extra cycles charged by the mode |

## Verification
Each decode branch is tried with postbytes at both ends of its offset or adjust field. This tells the sign handling of the 5-bit, 9-bit and 4-bit fields apart from plain zero extension. Bases sitting near 0x0000 and 0xFFFF expose any carry that escapes the 16-bit wrap. The PC is used as a base in the zero-, one- and two-byte modes, which shows whether the fetched-byte count is added. Accumulator values with the top bit set separate zero extension of A and B from sign extension. Slowed handshakes and a second `start` raised mid-request show that the result depends on neither acknowledge timing nor requests made while busy.

// File: rtl/idx_pkg.sv
package idx_pkg;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned MAX_BYTES = ADDR_W / DATA_W;
    localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int unsigned XCYC_W    = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        BASE_X  = 2'd0,
        BASE_Y  = 2'd1,
        BASE_SP = 2'd2,
        BASE_PC = 2'd3
    } base_e;

    typedef enum logic [3:0] {
        AM_CONST5,
        AM_AUTO,
        AM_CONST9,
        AM_CONST16,
        AM_IND16,
        AM_ACC_A,
        AM_ACC_B,
        AM_ACC_D,
        AM_IND_D
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MEM,
        ST_DONE
    } seq_e;

    typedef struct packed {
        amode_e             mode;
        base_e              base;
        logic [CNT_W-1:0]   nbytes;
        logic               indirect;
        logic [XCYC_W-1:0]  extra;
    } mode_info_t;

    // Nested priority decode of one postbyte.
    function automatic mode_info_t decode_postbyte(byte_t pb);
        mode_info_t m;
        m.mode     = AM_CONST5;
        m.base     = base_e'(pb[7:6]);
        m.nbytes   = '0;
        m.indirect = 1'b0;
        m.extra    = '0;
        if (!pb[5]) begin
            m.mode = AM_CONST5;
        end else if (pb[7:6] != 2'b11) begin
            m.mode = AM_AUTO;
        end else begin
            m.base = base_e'(pb[4:3]);
            if (pb[2:0] == 3'b011) begin
                m.mode     = AM_IND16;
                m.nbytes   = CNT_W'(2);
                m.indirect = 1'b1;
                m.extra    = XCYC_W'(1);
            end else if (!pb[2]) begin
                if (pb[1]) begin
                    m.mode   = AM_CONST16;
                    m.nbytes = CNT_W'(2);
                    m.extra  = XCYC_W'(1);
                end else begin
                    m.mode   = AM_CONST9;
                    m.nbytes = CNT_W'(1);
                end
            end else begin
                unique case (pb[1:0])
                    2'b00: m.mode = AM_ACC_A;
                    2'b01: m.mode = AM_ACC_B;
                    2'b10: m.mode = AM_ACC_D;
                    default: begin
                        m.mode     = AM_IND_D;
                        m.indirect = 1'b1;
                        m.extra    = XCYC_W'(1);
                    end
                endcase
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/idx_ofs_fetch.sv
module idx_ofs_fetch
    import idx_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] need,
    input  logic          fetch_ack,
    input  byte_t         fetch_data,
    output logic          fetch_req,
    output addr_t         ofs,
    output logic [CW-1:0] got,
    output logic          drained
);
    logic [CW-1:0] remain_q;

    assign fetch_req = (remain_q != '0);
    assign drained   = (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            got      <= '0;
            ofs      <= '0;
        end else if (load) begin
            remain_q <= need;
            got      <= '0;
            ofs      <= '0;
        end else if (fetch_req && fetch_ack) begin
            // first byte ends up in the high half
            ofs      <= {ofs[ADDR_W-DATA_W-1:0], fetch_data};
            remain_q <= remain_q - CW'(1);
            got      <= got + CW'(1);
        end
    end
endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
    import idx_pkg::*;
(
    input  mode_info_t info,
    input  logic [4:0] field,
    input  addr_t      rx,
    input  addr_t      ry,
    input  addr_t      rsp,
    input  addr_t      rpc,
    input  byte_t      acc_a,
    input  byte_t      acc_b,
    input  addr_t      ofs,
    output addr_t      sum,
    output addr_t      wb_val
);
    addr_t base, adj, addend;

    always_comb begin
        unique case (info.base)
            BASE_X:  base = rx;
            BASE_Y:  base = ry;
            BASE_SP: base = rsp;
            default: base = rpc;
        endcase

        adj = field[3] ? {{(ADDR_W-4){1'b1}}, field[3:0]}
                       : addr_t'(field[3:0]) + addr_t'(1);
        wb_val = base + adj;

        unique case (info.mode)
            AM_CONST5:  addend = {{(ADDR_W-5){field[4]}}, field[4:0]};
            AM_AUTO:    addend = field[4] ? adj : '0;
            AM_CONST9:  addend = {{(ADDR_W-DATA_W-1){field[0]}}, field[0], ofs[DATA_W-1:0]};
            AM_CONST16,
            AM_IND16:   addend = ofs;
            AM_ACC_A:   addend = addr_t'(acc_a);
            AM_ACC_B:   addend = addr_t'(acc_b);
            default:    addend = {acc_a, acc_b};
        endcase

        sum = base + addend;
    end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
    import idx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  postbyte,
    input  logic [15:0] reg_x,
    input  logic [15:0] reg_y,
    input  logic [15:0] reg_sp,
    input  logic [15:0] reg_pc,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    output logic        fetch_req,
    input  logic        fetch_ack,
    input  logic [7:0]  fetch_data,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic        done,
    output logic [15:0] eff_addr,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_data,
    output logic [1:0]  extra_cycles
);
    seq_e       st_q;
    mode_info_t info_q;
    logic [4:0] field_q;
    addr_t      x_q, y_q, sp_q, pc_q;
    byte_t      a_q, b_q;
    addr_t      ea_q, maddr_q, wbv_q;
    logic       wb_q;

    addr_t            ofs, sum, wb_val, pc_adj;
    logic [CNT_W-1:0] got;
    logic             drained;
    logic             accept;

    assign accept = (st_q == ST_IDLE) && start;
    assign pc_adj = pc_q + addr_t'(got);

    idx_ofs_fetch #(.CW(CNT_W)) i_fetch (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .need       (decode_postbyte(postbyte).nbytes),
        .fetch_ack  (fetch_ack),
        .fetch_data (fetch_data),
        .fetch_req  (fetch_req),
        .ofs        (ofs),
        .got        (got),
        .drained    (drained)
    );

    idx_addr_calc i_calc (
        .info   (info_q),
        .field  (field_q),
        .rx     (x_q),
        .ry     (y_q),
        .rsp    (sp_q),
        .rpc    (pc_adj),
        .acc_a  (a_q),
        .acc_b  (b_q),
        .ofs    (ofs),
        .sum    (sum),
        .wb_val (wb_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            info_q  <= '0;
            field_q <= '0;
            x_q     <= '0;
            y_q     <= '0;
            sp_q    <= '0;
            pc_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            ea_q    <= '0;
            maddr_q <= '0;
            wbv_q   <= '0;
            wb_q    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        info_q  <= decode_postbyte(postbyte);
                        field_q <= postbyte[4:0];
                        x_q     <= reg_x;
                        y_q     <= reg_y;
                        sp_q    <= reg_sp;
                        pc_q    <= reg_pc;
                        a_q     <= acc_a;
                        b_q     <= acc_b;
                        wb_q    <= 1'b0;
                        st_q    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (drained) begin
                        wbv_q <= wb_val;
                        wb_q  <= (info_q.mode == AM_AUTO);
                        if (info_q.indirect) begin
                            maddr_q <= sum;
                            st_q    <= ST_MEM;
                        end else begin
                            ea_q <= sum;
                            st_q <= ST_DONE;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        ea_q <= mem_rdata;
                        st_q <= ST_DONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done         = (st_q == ST_DONE);
    assign eff_addr     = ea_q;
    assign wb_en        = done && wb_q;
    assign wb_sel       = info_q.base;
    assign wb_data      = wbv_q;
    assign extra_cycles = info_q.extra;
    assign mem_req      = (st_q == ST_MEM);
    assign mem_addr     = maddr_q;
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        fetch_req,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic        wb_en,
    input logic [1:0]  extra_cycles
);
    // R12: quiet right after a reset cycle
    p_reset_quiet_r12: assert property (@(posedge clk)
        rst |=> (!done && !fetch_req && !mem_req));

    // R11: done never lasts two cycles
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: only one handshake port active at a time
    p_one_port_r11: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req && mem_req));

    // R2: write-back only appears with the done strobe
    p_wb_with_done_r2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    // R2: auto-modify modes charge no extra cycle
    p_auto_no_extra_r2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (extra_cycles == 2'd0));

    // R6: pointer read address held until acknowledged
    p_mem_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind idx_addr_gen idx_addr_gen_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_req    (fetch_req),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .done         (done),
    .wb_en        (wb_en),
    .extra_cycles (extra_cycles)
);

// File: tb/test_idx_addr_gen.sv
module test_idx_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        fetch_req, fetch_ack;
    logic [7:0]  fetch_data;
    logic        mem_req, mem_ack;
    logic [15:0] mem_addr, mem_rdata;
    logic        done, wb_en;
    logic [15:0] eff_addr, wb_data;
    logic [1:0]  wb_sel, extra_cycles;

    int n_checks = 0;
    int n_fails  = 0;
    int fetch_seen = 0;
    int mem_seen   = 0;
    bit slow = 1'b0;
    bit stall_tog = 1'b0;
    logic [7:0] ofs_q[$];

    // expected values
    logic [15:0] e_ea, e_wbv;
    bit          e_wb;
    int          e_sel, e_extra, e_nf, e_nm;

    always #4 clk = ~clk;   // 125 MHz

    idx_addr_gen i_idx_addr_gen (
        .clk(clk), .rst(rst), .start(start), .postbyte(postbyte),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .acc_a(acc_a), .acc_b(acc_b),
        .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .eff_addr(eff_addr), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_data(wb_data), .extra_cycles(extra_cycles)
    );

    function automatic logic [7:0] mem_byte(int a);
        int m = a & 16'hFFFF;
        return 8'((m * 37 + 11) ^ (m >> 8));
    endfunction

    // big-endian word: high byte at the lower address
    function automatic logic [15:0] mem_word(int a);
        return {mem_byte(a), mem_byte((a + 1) & 16'hFFFF)};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // responders for the byte stream and the word read port
    initial begin
        fetch_ack = 1'b0; fetch_data = '0; mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            fetch_ack = 1'b0;
            mem_ack   = 1'b0;
            stall_tog = ~stall_tog;
            if (fetch_req && !(slow && stall_tog)) begin
                fetch_ack = 1'b1;
                fetch_seen++;
                if (ofs_q.size() > 0) fetch_data = ofs_q.pop_front();
                else fetch_data = 8'h00;
            end
            if (mem_req && !(slow && stall_tog)) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_word(int'(mem_addr));
                mem_seen++;
            end
        end
    end

    function automatic int pick(int idx, int x, int y, int sp, int pc);
        case (idx)
            0: return x;
            1: return y;
            2: return sp;
            default: return pc;
        endcase
    endfunction

    task automatic model(logic [7:0] pb, int x, int y, int sp, int pc,
                         int a, int b, int b0, int b1);
        int base, off, adj, nv, ptr, sel;
        e_wb = 0; e_extra = 0; e_nf = 0; e_nm = 0; e_sel = 0; e_wbv = '0;
        if (pb[5] == 1'b0) begin
            sel = int'(pb[7:6]);
            off = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
            e_ea = 16'((pick(sel, x, y, sp, pc) + off) & 16'hFFFF);
        end else if (pb[7:6] != 2'b11) begin
            sel  = int'(pb[7:6]);
            base = pick(sel, x, y, sp, pc);
            adj  = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
            nv   = (base + adj) & 16'hFFFF;
            e_wb = 1; e_sel = sel; e_wbv = 16'(nv);
            e_ea = pb[4] ? 16'(nv) : 16'(base);
        end else begin
            sel = int'(pb[4:3]);
            if (pb[2:0] == 3'b011) begin
                e_nf = 2; off = b0 * 256 + b1;
                ptr  = (pick(sel, x, y, sp, pc + 2) + off) & 16'hFFFF;
                e_ea = mem_word(ptr); e_extra = 1; e_nm = 1;
            end else if (pb[2] == 1'b0) begin
                if (pb[1]) begin
                    e_nf = 2; off = b0 * 256 + b1; e_extra = 1;
                end else begin
                    e_nf = 1; off = pb[0] ? b0 - 256 : b0;
                end
                e_ea = 16'((pick(sel, x, y, sp, pc + e_nf) + off) & 16'hFFFF);
            end else begin
                case (pb[1:0])
                    2'b00: off = a;
                    2'b01: off = b;
                    default: off = a * 256 + b;
                endcase
                ptr = (pick(sel, x, y, sp, pc) + off) & 16'hFFFF;
                if (pb[1:0] == 2'b11) begin
                    e_ea = mem_word(ptr); e_extra = 1; e_nm = 1;
                end else begin
                    e_ea = 16'(ptr);
                end
            end
        end
    endtask

    task automatic run(string req, logic [7:0] pb, int x, int y, int sp, int pc,
                       int a, int b, int b0, int b1, bit poke);
        int n;
        model(pb, x, y, sp, pc, a, b, b0, b1);
        ofs_q.delete();
        if (e_nf > 0) ofs_q.push_back(8'(b0));
        if (e_nf > 1) ofs_q.push_back(8'(b1));
        fetch_seen = 0;
        mem_seen   = 0;
        @(negedge clk);
        postbyte = pb; reg_x = 16'(x); reg_y = 16'(y); reg_sp = 16'(sp);
        reg_pc = 16'(pc); acc_a = 8'(a); acc_b = 8'(b);
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            start = 1'b1; postbyte = 8'h85; reg_sp = 16'h1234;
        end else start = 1'b0;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "done seen", int'(done), 1);
        check(eff_addr == e_ea, req, "eff_addr", int'(eff_addr), int'(e_ea));
        check(int'(extra_cycles) == e_extra, req, "extra_cycles", int'(extra_cycles), e_extra);
        check(wb_en == e_wb, req, "wb_en", int'(wb_en), int'(e_wb));
        if (e_wb) begin
            check(int'(wb_sel) == e_sel, req, "wb_sel", int'(wb_sel), e_sel);
            check(wb_data == e_wbv, req, "wb_data", int'(wb_data), int'(e_wbv));
        end
        check(fetch_seen == e_nf, req, "bytes fetched", fetch_seen, e_nf);
        check(mem_seen == e_nm, req, "words read", mem_seen, e_nm);
        @(negedge clk);
        check(done == 1'b0, "R11", "done width", int'(done), 0);
        if (poke) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check(done == 1'b0, "R11", "start while busy ignored", int'(done), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && fetch_req == 1'b0 && mem_req == 1'b0, "R12",
              "idle outputs in reset", int'({done, fetch_req, mem_req}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && fetch_req == 1'b0 && mem_req == 1'b0, "R12",
              "idle outputs after reset", int'({done, fetch_req, mem_req}), 0);

        // R1 short constant offsets, all bases
        run("R1", 8'h0F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R1", 8'h50, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R1", 8'h85, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R9", 8'hDF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        // R2 / R3 auto modify
        run("R3", 8'h23, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R3", 8'h78, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R2", 8'hAF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R2", 8'h37, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R2", 8'h40, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        // R10 wrap cases
        run("R10", 8'hB0, 16'h1000, 16'h2000, 16'hFFFF, 16'h4000, 0, 0, 0, 0, 0);
        run("R10", 8'h10, 16'h0002, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 0);
        run("R10", 8'hE2, 16'hFFF0, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h00, 8'h20, 0);
        // R4 nine-bit offsets
        run("R4", 8'hE0, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h7F, 0, 0);
        run("R4", 8'hE1, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h01, 0, 0);
        run("R9", 8'hF8, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h10, 0, 0);
        // R5 sixteen-bit offsets
        run("R5", 8'hE2, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h12, 8'h34, 0);
        run("R9", 8'hFA, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h80, 8'h01, 0);
        // R6 indirect with 16-bit offset
        run("R6", 8'hEB, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h01, 8'h02, 0);
        run("R6", 8'hFB, 16'h1000, 16'h2000, 16'h3000, 16'hFFFE, 0, 0, 8'h00, 8'h05, 0);
        // R7 accumulator offsets
        run("R7", 8'hE4, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h80, 8'h11, 0, 0, 0);
        run("R7", 8'hED, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'hF0, 0, 0, 0);
        run("R7", 8'hF6, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'hF1, 8'h23, 0, 0, 0);
        // R8 D-offset indirect
        run("R8", 8'hE7, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h01, 8'h02, 0, 0, 0);

        // slowed handshakes and start raised while busy (R11)
        slow = 1'b1;
        run("R5", 8'hEA, 16'h1000, 16'hABCD, 16'h3000, 16'h4000, 0, 0, 8'hFF, 8'hFF, 1);
        run("R6", 8'hE3, 16'h0100, 16'h2000, 16'h3000, 16'h4000, 0, 0, 8'h00, 8'h10, 1);
        run("R8", 8'hFF, 16'h1000, 16'h2000, 16'h3000, 16'h8000, 8'h7F, 8'hFF, 0, 0, 1);
        run("R11", 8'h0F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, 0, 1);
        slow = 1'b0;

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule